// File: doc/BRIEF.md
# Sparse-Tree Conditional-Sum Adder

This block adds two unsigned operands and a carry-in, giving the sum and the carry-out. Its carry network does not produce a carry for every bit. The operands are divided into slices of a fixed width, four bits by default. A parallel-prefix tree of two-input merge steps produces only the carries that enter each slice, and it produces all of them at the same time.

Inside each slice, a side path uses ripple logic to form two candidate results: one that assumes the incoming carry is 0 and one that assumes it is 1. The sparse carry for the slice then drives a 2:1 multiplexer that picks one of the two. The carry into the lowest slice is the external carry-in. The carry-out is taken from the two candidate carries of the top slice, picked the same way as that slice's sum.

The adder logic is combinational. A parameter adds a register on the sum and carry-out outputs, which are then valid one clock after the operands.

Top module: `sparse_cs_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `c_i`) modulo 2^WIDTH for every operand pair.
- R2: `cout_o` equals bit WIDTH of the (WIDTH+1)-bit sum `a_i` + `b_i` + `c_i`.
- R3: The carry entering each slice k > 0 (at bit position k*GROUP) equals the true carry into that bit. For example, adding 1 to an operand whose low k*GROUP bits are all ones gives a sum of exactly 2^(k*GROUP).
- R4: Each slice's two candidate results differ by exactly one. The slice's sparse carry selects between them, so when every bit propagates (`a_i` XOR `b_i` is all ones), toggling `c_i` switches the result between all ones with carry-out 0 and all zeros with carry-out 1.
- R5: The lowest slice is selected by `c_i` directly. With both operands zero, the sum equals `c_i` and `cout_o` is 0.
- R6: An all-ones operand plus one, with `c_i` = 0, gives a sum of zero and `cout_o` = 1.
- R7: With OUT_REG = 1, `sum_o` and `cout_o` are zero while `rst_ni` is low. After reset they show the result of the operands present at the previous rising edge of `clk_i`, and they do not change between edges.
- R8: With OUT_REG = 0 the outputs follow the operands with no clock delay. The same structure also works at other widths that are a power-of-two number of power-of-two slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum, WIDTH bits |
| cout_o | output | 1 | Carry-out of the top bit |

## Verification
The bench builds two instances. The first uses the default 64-bit width with 4-bit slices and the output register on. It exercises a four-level group tree, a carry crossing each of the fifteen slice boundaries, and the one-cycle output latency together with the reset value. The second is a 16-bit instance with the register off. It shows that the group tree narrows to two levels, that the outputs settle within the same cycle, and that the same vectors still add correctly at a width where the carry-out comes from bit 15.

// File: rtl/sparse_add_pkg.sv
package sparse_add_pkg;

  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // radix-2 merge: hi covers the more significant span
  function automatic pg_t pg_merge(pg_t hi, pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/sa_group_pg.sv
module sa_group_pg
  import sparse_add_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  output logic [GW-1:0] prop_o,
  output logic [GW-1:0] gen_o,
  output pg_t           grp_o
);

  localparam int LV = $clog2(GW);

  assign prop_o = a_i ^ b_i;
  assign gen_o  = a_i & b_i;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int NN = GW >> l;
    pg_t node [NN];
    for (genvar j = 0; j < NN; j++) begin : g_nd
      if (l == 0) begin : g_leaf
        assign node[j] = '{g: gen_o[j], p: prop_o[j]};
      end else begin : g_merge
        assign node[j] = pg_merge(g_lv[l-1].node[2*j+1], g_lv[l-1].node[2*j]);
      end
    end
  end

  assign grp_o = g_lv[LV].node[0];

endmodule

// File: rtl/sa_sparse_tree.sv
module sa_sparse_tree
  import sparse_add_pkg::*;
#(
  parameter int NG = 16
) (
  input  pg_t           grp_i [NG],
  input  logic          c_i,
  output logic [NG-1:0] cin_o,
  output logic          cout_o
);

  localparam int LV = $clog2(NG);

  pg_t ks [LV+1][NG];

  for (genvar j = 0; j < NG; j++) begin : g_l0
    assign ks[0][j] = grp_i[j];
  end

  // Kogge-Stone over slice-level pairs, span doubles each level
  for (genvar l = 1; l <= LV; l++) begin : g_lv
    localparam int D = 1 << (l - 1);
    for (genvar j = 0; j < NG; j++) begin : g_nd
      if (j >= D) begin : g_mrg
        assign ks[l][j] = pg_merge(ks[l-1][j], ks[l-1][j-D]);
      end else begin : g_pass
        assign ks[l][j] = ks[l-1][j];
      end
    end
  end

  assign cin_o[0] = c_i;
  for (genvar j = 1; j < NG; j++) begin : g_c
    assign cin_o[j] = ks[LV][j-1].g | (ks[LV][j-1].p & c_i);
  end
  assign cout_o = ks[LV][NG-1].g | (ks[LV][NG-1].p & c_i);

endmodule

// File: rtl/sa_cond_sum.sv
module sa_cond_sum #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] prop_i,
  input  logic [GW-1:0] gen_i,
  input  logic          sel_i,
  output logic [GW-1:0] sum0_o,
  output logic [GW-1:0] sum1_o,
  output logic          co0_o,
  output logic          co1_o,
  output logic [GW-1:0] sum_o,
  output logic          co_o
);

  logic c0, c1;

  always_comb begin
    c0 = 1'b0;
    c1 = 1'b1;
    for (int i = 0; i < GW; i++) begin
      sum0_o[i] = prop_i[i] ^ c0;
      sum1_o[i] = prop_i[i] ^ c1;
      c0 = gen_i[i] | (prop_i[i] & c0);
      c1 = gen_i[i] | (prop_i[i] & c1);
    end
    co0_o = c0;
    co1_o = c1;
  end

  assign sum_o = sel_i ? sum1_o : sum0_o;
  assign co_o  = sel_i ? co1_o  : co0_o;

endmodule

// File: rtl/sparse_cs_adder.sv
module sparse_cs_adder
  import sparse_add_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int GROUP   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NG = WIDTH / GROUP;

  pg_t             grp_pg [NG];
  logic [NG-1:0]   grp_cin;
  logic [NG-1:0]   grp_co;
  logic [NG-1:0]   co0, co1;
  logic [WIDTH-1:0] prop, gen, sum0, sum1, sum_d;
  logic            tree_cout, cout_d;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    sa_group_pg #(.GW(GROUP)) u_pg (
      .a_i   (a_i[k*GROUP +: GROUP]),
      .b_i   (b_i[k*GROUP +: GROUP]),
      .prop_o(prop[k*GROUP +: GROUP]),
      .gen_o (gen[k*GROUP +: GROUP]),
      .grp_o (grp_pg[k])
    );

    sa_cond_sum #(.GW(GROUP)) u_cs (
      .prop_i(prop[k*GROUP +: GROUP]),
      .gen_i (gen[k*GROUP +: GROUP]),
      .sel_i (grp_cin[k]),
      .sum0_o(sum0[k*GROUP +: GROUP]),
      .sum1_o(sum1[k*GROUP +: GROUP]),
      .co0_o (co0[k]),
      .co1_o (co1[k]),
      .sum_o (sum_d[k*GROUP +: GROUP]),
      .co_o  (grp_co[k])
    );
  end

  sa_sparse_tree #(.NG(NG)) u_tree (
    .grp_i (grp_pg),
    .c_i   (c_i),
    .cin_o (grp_cin),
    .cout_o(tree_cout)
  );

  // carry-out from the top slice's conditional carries
  assign cout_d = grp_co[NG-1];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_d;
        cout_o <= cout_d;
      end
    end

    p_reg_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (sum_o == $past(sum_d)) && (cout_o == $past(cout_d)));
  end else begin : g_comb
    assign sum_o  = sum_d;
    assign cout_o = cout_d;

    p_comb_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o == a_i + b_i + WIDTH'(c_i));
  end

  p_sum_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_d == a_i + b_i + WIDTH'(c_i));

  p_cout_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {cout_d, sum_d} == {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(c_i));

  // side-path carry-out must agree with the prefix tree's top carry
  p_cout_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_d == tree_cout);

  p_low_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_d[0] == (a_i[0] ^ b_i[0] ^ c_i));

  p_all_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&a_i && b_i == WIDTH'(1) && !c_i) |-> (sum_d == '0 && cout_d));

  for (genvar k = 0; k < NG; k++) begin : g_chk
    p_cand_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      {co1[k], sum1[k*GROUP +: GROUP]} == {co0[k], sum0[k*GROUP +: GROUP]} + (GROUP+1)'(1));
    if (k > 0) begin : g_link
      p_sparse_link_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grp_cin[k] == grp_co[k-1]);
    end
  end

endmodule

// File: tb/sim_sparse_cs_adder.sv
module sim_sparse_cs_adder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] a, b;
  logic        c;
  logic [63:0] s_r;
  logic        co_r;
  logic [15:0] s_c;
  logic        co_c;

  int n_chk = 0;
  int n_bad = 0;
  logic [64:0] prev_exp = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sparse_cs_adder #(.WIDTH(64), .GROUP(4), .OUT_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .c_i(c),
    .sum_o(s_r), .cout_o(co_r)
  );

  sparse_cs_adder #(.WIDTH(16), .GROUP(4), .OUT_REG(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a[15:0]), .b_i(b[15:0]), .c_i(c),
    .sum_o(s_c), .cout_o(co_c)
  );

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic ci,
                       input string req);
    logic [64:0] exp;
    logic [16:0] exp16;
    @(negedge clk);
    a = x; b = y; c = ci;
    #1;
    exp16 = {1'b0, x[15:0]} + {1'b0, y[15:0]} + 17'(ci);
    check("R8 comb 16b", 65'({co_c, s_c}), 65'(exp16));
    check("R7 hold", {co_r, s_r}, prev_exp);
    @(posedge clk);
    #1;
    exp = {1'b0, x} + {1'b0, y} + 65'(ci);
    check(req, {co_r, s_r}, exp);
    prev_exp = exp;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; a = '0; b = '0; c = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", {co_r, s_r}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_exp = '0;
  endtask

  task automatic t_carry_in_only;
    apply('0, '0, 1'b1, "R5 cin only");
    apply('0, '0, 1'b0, "R5 zero");
  endtask

  task automatic t_boundary;
    for (int k = 1; k < 16; k++) begin
      apply((64'd1 << (4*k)) - 64'd1, 64'd1, 1'b0, "R3 slice boundary");
    end
    apply(64'h0000_0000_0000_000F, '0, 1'b1, "R3 cin into slice 1");
  endtask

  task automatic t_toggle;
    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, "R4 propagate cin0");
    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R4 propagate cin1");
    apply(64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0, 1'b1, "R4 propagate mix");
  endtask

  task automatic t_all_ones;
    apply('1, 64'd1, 1'b0, "R6 ones plus one");
    apply('1, '1, 1'b1, "R2 max cout");
    apply('1, '0, 1'b0, "R2 no cout");
  endtask

  task automatic t_alternating;
    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R1 alt A+A");
    apply(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1, "R1 alt 5+5");
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R2 msb only");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 R2 random");
    end
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_carry_in_only();
    t_boundary();
    t_toggle();
    t_all_ones();
    t_alternating();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule